// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Controller

This block drives one external asynchronous static memory channel, such as an SRAM or a NOR flash, on a 16-bit data bus. A host presents a request with address, write data, direction and byte enables. The controller raises chip select, then places the output-enable, write-enable and byte-lane strobes inside that access window according to programmable wait-state fields. At the end of the access it returns a one-cycle done pulse and, for reads, the data captured from the memory.

Every timing field is a small code with its own offset. The read, page and turnaround fields add one cycle. The write field adds two. The write-enable delay adds one cycle. The output-enable delay is used as written, so zero means the strobe is asserted in the first cycle of the access. Because of the offsets, the all-ones code of each field gives the longest count (32, 33 or 16 cycles) with no special decoding. An optional wait input from the memory can stretch an access up to a programmable timeout. A write-protect control turns writes into accesses that never pulse the write strobe.

The configuration inputs are expected to be static registers that change only while the controller is idle.

Top module: `asyncmem_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, chip select is at its inactive level, `mem_oe_n`, `mem_we_n` and both bits of `mem_bl_n` are high, `rsp_done` is low and `req_ready` is high.
- R2: With `cfg_cs_high` = 1, chip select is active high. With `cfg_cs_high` = 0, it is active low.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Chip select becomes active in the next cycle. A read that is not a page hit holds chip select for `cfg_rd_wait` + 1 cycles (code 31 gives 32). The address stays stable throughout.
- R4: A write holds chip select for `cfg_wr_wait` + 2 cycles (code 31 gives 33).
- R5: During a read, `mem_oe_n` is low from access cycle `cfg_oe_dly` (cycle 0 being the first chip-select cycle) through the last access cycle. If `cfg_oe_dly` exceeds the last cycle index of the programmed access time, it stays high. `mem_din` is captured on the last access cycle into `rsp_rdata`. `rsp_done` pulses for one cycle right after chip select drops.
- R6: During a write, `mem_we_n` is low from access cycle `cfg_we_dly` + 1 through the last access cycle. It never goes low if `cfg_we_dly` + 1 exceeds the last cycle index of the programmed access time. It is never low together with `mem_oe_n`.
- R7: When `cfg_pg_en` = 1, a read is a page hit if the previously accepted request was a read and both addresses agree in bits [AW-1:2]. A page-hit read lasts `cfg_pg_wait` + 1 cycles (code 31 gives 32).
- R8: After every access, `cfg_turn` + 1 turnaround cycles follow, counting the cycle that carries `rsp_done`. During them `req_ready` is low, chip select stays inactive and a waiting request is held off.
- R9: When `cfg_ew_en` = 1 and `mem_wait` is high on the last programmed access cycle, the access is extended while `mem_wait` stays high. The extension is at most (`cfg_ew_tmo` + 1) × 16 cycles, so code 0 gives 16. Strobes keep their state during the extension.
- R10: When `cfg_wprot` = 1, a write runs its full access time and returns `rsp_done`, but `mem_we_n` stays high, `mem_dout_en` stays low and the memory is left unchanged.
- R11: During an access of either direction, `mem_bl_n[i]` equals the inverse of the accepted `req_be[i]` (bit 0 is the low byte, bit 1 the high byte). A write drives `req_wdata` on `mem_dout` with `mem_dout_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_oe_dly | input | 4 | Output-enable delay code, n cycles |
| cfg_we_dly | input | 4 | Write-enable delay code, n+1 cycles |
| cfg_rd_wait | input | 5 | Read access code, n+1 cycles |
| cfg_wr_wait | input | 5 | Write access code, n+2 cycles |
| cfg_pg_wait | input | 5 | Page-hit read access code, n+1 cycles |
| cfg_turn | input | 4 | Turnaround code, n+1 cycles |
| cfg_ew_tmo | input | 10 | External-wait timeout code, (n+1)×16 cycles |
| cfg_ew_en | input | 1 | Enable the external-wait input |
| cfg_pg_en | input | 1 | Enable page-hit read timing |
| cfg_cs_high | input | 1 | Chip select polarity, 1 = active high |
| cfg_wprot | input | 1 | Write protect |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Halfword address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| mem_cs | output | 1 | Chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bl_n | output | 2 | Byte-lane strobes, active low |
| mem_addr | output | 20 | Memory address |
| mem_dout | output | 16 | Write data to memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | 16 | Read data from memory |
| mem_wait | input | 1 | Memory wait request, active high |

## Verification
The assertions assume that the polarity and write-protect controls only change while `req_ready` is high, so the active chip-select level they compare against is fixed during an access and its turnaround. The bench loads a complete new configuration only in the idle cycle in which it sees `req_ready`. It raises `mem_wait` only inside chip-select cycles, using a per-access cycle threshold, and keeps each request asserted until it is accepted. That way the expected length, strobe counts and captured data follow from the configuration and the threshold alone.

// File: rtl/asyncmem_ctrl.sv
module asyncmem_ctrl #(
  parameter int AW   = 20,
  parameter int DW   = 16,
  parameter int BEW  = DW / 8,
  parameter int PGB  = 2,
  parameter int OEW  = 4,
  parameter int WENW = 4,
  parameter int RDW  = 5,
  parameter int WRW  = 5,
  parameter int PGW  = 5,
  parameter int TNW  = 4,
  parameter int EWW  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OEW-1:0]  cfg_oe_dly,
  input  logic [WENW-1:0] cfg_we_dly,
  input  logic [RDW-1:0]  cfg_rd_wait,
  input  logic [WRW-1:0]  cfg_wr_wait,
  input  logic [PGW-1:0]  cfg_pg_wait,
  input  logic [TNW-1:0]  cfg_turn,
  input  logic [EWW-1:0]  cfg_ew_tmo,
  input  logic            cfg_ew_en,
  input  logic            cfg_pg_en,
  input  logic            cfg_cs_high,
  input  logic            cfg_wprot,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [BEW-1:0]  req_be,
  output logic            rsp_done,
  output logic [DW-1:0]   rsp_rdata,
  output logic            mem_cs,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic [BEW-1:0]  mem_bl_n,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_dout,
  output logic            mem_dout_en,
  input  logic [DW-1:0]   mem_din,
  input  logic            mem_wait
);
  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LENW = maxi(maxi(maxi(RDW, WRW), maxi(PGW, TNW)), maxi(OEW, WENW)) + 1;
  localparam int TOW  = EWW + 5;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_TURN} st_t;

  st_t              st;
  logic [LENW-1:0]  cnt, last_q, len_m1;
  logic [TOW-1:0]   ext, tmo;
  logic             wr_q, pv_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [BEW-1:0]   be_q;
  logic [AW-PGB-1:0] pp_q;

  wire in_acc = (st == S_ACC);
  wire accept = req_valid && (st == S_IDLE);
  wire pg_hit = cfg_pg_en && !req_write && pv_q && (req_addr[AW-1:PGB] == pp_q);
  wire at_end = (cnt == last_q);

  assign tmo = (TOW'(cfg_ew_tmo) + TOW'(1)) << 4;

  wire stall = cfg_ew_en && mem_wait && (ext != tmo);
  wire fin   = in_acc && at_end && !stall;

  always_comb begin
    if (req_write)   len_m1 = LENW'(cfg_wr_wait) + LENW'(1);
    else if (pg_hit) len_m1 = LENW'(cfg_pg_wait);
    else             len_m1 = LENW'(cfg_rd_wait);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      last_q    <= '0;
      ext       <= '0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      pv_q      <= 1'b0;
      pp_q      <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= fin;
      if (fin && !wr_q) rsp_rdata <= mem_din;
      case (st)
        S_IDLE: if (accept) begin
          st      <= S_ACC;
          cnt     <= '0;
          ext     <= '0;
          last_q  <= len_m1;
          wr_q    <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          pv_q    <= !req_write;
          pp_q    <= req_addr[AW-1:PGB];
        end
        S_ACC: begin
          if (!at_end)    cnt <= cnt + LENW'(1);
          else if (stall) ext <= ext + TOW'(1);
          else begin
            st  <= S_TURN;
            cnt <= '0;
          end
        end
        S_TURN: begin
          if (cnt == LENW'(cfg_turn)) st <= S_IDLE;
          else                        cnt <= cnt + LENW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign mem_cs      = cfg_cs_high ? in_acc : !in_acc;
  assign mem_oe_n    = !(in_acc && !wr_q && (cnt >= LENW'(cfg_oe_dly)));
  assign mem_we_n    = !(in_acc && wr_q && !cfg_wprot && (cnt > LENW'(cfg_we_dly)));
  assign mem_bl_n    = in_acc ? ~be_q : '1;
  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q;
  assign mem_dout_en = in_acc && wr_q && !cfg_wprot;
endmodule

// File: rtl/asyncmem_ctrl_chk.sv
module asyncmem_ctrl_chk #(
  parameter int AW  = 20,
  parameter int BEW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_cs_high,
  input logic           cfg_wprot,
  input logic           req_ready,
  input logic           rsp_done,
  input logic           mem_cs,
  input logic           mem_oe_n,
  input logic           mem_we_n,
  input logic [BEW-1:0] mem_bl_n,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_dout_en
);
  logic cs_act;
  assign cs_act = (mem_cs == cfg_cs_high);

  assert_we_inside_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> cs_act && mem_oe_n);

  assert_oe_inside_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> cs_act && !mem_dout_en);

  assert_wp_blocks_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wprot |-> mem_we_n && !mem_dout_en);

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cs_act);

  assert_done_after_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !cs_act && $past(cs_act));

  assert_lanes_in_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_bl_n != '1) |-> cs_act);

  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act && $past(cs_act) |-> $stable(mem_addr));

  assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> mem_oe_n && mem_we_n && !mem_dout_en);
endmodule

bind asyncmem_ctrl asyncmem_ctrl_chk #(.AW(AW), .BEW(BEW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cs_high(cfg_cs_high), .cfg_wprot(cfg_wprot),
  .req_ready(req_ready), .rsp_done(rsp_done), .mem_cs(mem_cs),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bl_n(mem_bl_n),
  .mem_addr(mem_addr), .mem_dout_en(mem_dout_en)
);

// File: tb/asyncmem_ctrl_test.sv
`timescale 1ns/1ps
module asyncmem_ctrl_test;
  localparam int AW = 20, DW = 16, BEW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cfg_oe_dly, cfg_we_dly, cfg_turn;
  logic [4:0] cfg_rd_wait, cfg_wr_wait, cfg_pg_wait;
  logic [9:0] cfg_ew_tmo;
  logic cfg_ew_en, cfg_pg_en, cfg_cs_high, cfg_wprot;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [BEW-1:0] req_be = '0;
  logic req_ready, rsp_done, mem_cs, mem_oe_n, mem_we_n, mem_dout_en;
  logic [DW-1:0] rsp_rdata, mem_dout;
  logic [BEW-1:0] mem_bl_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_din = 16'hDEAD;
  logic mem_wait = 1'b0;

  always #2.5 clk = ~clk;

  asyncmem_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_oe_dly(cfg_oe_dly), .cfg_we_dly(cfg_we_dly),
    .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait), .cfg_pg_wait(cfg_pg_wait),
    .cfg_turn(cfg_turn), .cfg_ew_tmo(cfg_ew_tmo), .cfg_ew_en(cfg_ew_en),
    .cfg_pg_en(cfg_pg_en), .cfg_cs_high(cfg_cs_high), .cfg_wprot(cfg_wprot),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_cs(mem_cs),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bl_n(mem_bl_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din), .mem_wait(mem_wait)
  );

  typedef struct {
    int oe, we, rd, wr, pg, tn, tmo;
    bit ew, pgen, csh, wp;
  } cfg_t;

  cfg_t nx;
  int checks = 0, fails = 0;
  bit done_flag = 0;
  logic [15:0] model [16];
  logic [15:0] shadow [16];
  int cscnt = 0, oecnt = 0, wecnt = 0, wait_until = 0, exp_turn = 0;
  bit lane_bad = 0, idle_bad = 0, pv = 0;
  int pp = 0;
  logic [1:0] exp_be = 2'b00;

  function automatic bit cs_on();
    return cfg_cs_high ? mem_cs : !mem_cs;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cs_on()) begin
      mem_wait = (cscnt < wait_until);
      if (!mem_oe_n) begin
        mem_din = model[mem_addr[3:0]] + 16'(oecnt);
        oecnt++;
      end else begin
        mem_din = 16'hDEAD;
      end
      if (!mem_we_n && mem_dout_en) begin
        if (!mem_bl_n[0]) model[mem_addr[3:0]][7:0]  = mem_dout[7:0];
        if (!mem_bl_n[1]) model[mem_addr[3:0]][15:8] = mem_dout[15:8];
        wecnt++;
      end
      if (mem_bl_n != ~exp_be) lane_bad = 1;
      cscnt++;
    end else begin
      mem_wait = 1'b0;
      mem_din  = 16'hDEAD;
      if (rst_n && (mem_bl_n != 2'b11 || !mem_oe_n || !mem_we_n || mem_dout_en)) idle_bad = 1;
    end
  end

  task automatic apply_cfg();
    cfg_oe_dly  = 4'(nx.oe);
    cfg_we_dly  = 4'(nx.we);
    cfg_rd_wait = 5'(nx.rd);
    cfg_wr_wait = 5'(nx.wr);
    cfg_pg_wait = 5'(nx.pg);
    cfg_turn    = 4'(nx.tn);
    cfg_ew_tmo  = 10'(nx.tmo);
    cfg_ew_en   = nx.ew;
    cfg_pg_en   = nx.pgen;
    cfg_cs_high = nx.csh;
    cfg_wprot   = nx.wp;
  endtask

  task automatic clear_nx();
    nx.oe = 0; nx.we = 0; nx.rd = 0; nx.wr = 0; nx.pg = 0; nx.tn = 0; nx.tmo = 0;
    nx.ew = 0; nx.pgen = 0; nx.csh = 0; nx.wp = 0;
  endtask

  task automatic txn(bit wr, int a, logic [15:0] wd, logic [1:0] be, int wu);
    int held, hold_cs, L, T, endc, eo, ew;
    bit hit;
    string tag;
    logic [15:0] erd;
    held = 0; hold_cs = 0;
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = wd; req_be = be;
    while (!req_ready) begin
      if (cs_on()) hold_cs++;
      held++;
      @(negedge clk); #1;
    end
    chk("R8", "turnaround cycles before ready", held, exp_turn);
    chk("R8", "chip select during hold-off", hold_cs, 0);
    apply_cfg();
    exp_be = be; wait_until = wu; cscnt = 0; oecnt = 0; wecnt = 0; lane_bad = 0;
    hit = nx.pgen && !wr && pv && ((a >> 2) == pp);
    pv = !wr; pp = a >> 2;
    @(posedge clk); @(negedge clk); #1;
    req_valid = 1'b0;
    while (!rsp_done) begin @(negedge clk); #1; end
    L = wr ? nx.wr + 2 : (hit ? nx.pg + 1 : nx.rd + 1);
    T = (nx.tmo + 1) * 16;
    endc = L - 1;
    if (nx.ew && wu > L - 1) endc = (wu < L - 1 + T) ? wu : L - 1 + T;
    tag = (endc != L - 1) ? "R9" : (wr ? "R4" : (hit ? "R7" : "R3"));
    chk(tag, "chip select cycles", cscnt, endc + 1);
    chk("R5", "chip select off in done cycle", int'(cs_on()), 0);
    chk("R11", "byte lanes during access", int'(lane_bad), 0);
    if (!wr) begin
      eo = (nx.oe <= L - 1) ? endc + 1 - nx.oe : 0;
      chk("R5", "output enable cycles", oecnt, eo);
      erd = (eo > 0) ? shadow[a] + 16'(eo - 1) : 16'hDEAD;
      chk("R5", "read data", int'(rsp_rdata), int'(erd));
      chk("R6", "no write strobe on read", wecnt, 0);
    end else begin
      ew = (!nx.wp && nx.we < L - 1) ? endc - nx.we : 0;
      chk(nx.wp ? "R10" : "R6", "write enable cycles", wecnt, ew);
      chk("R6", "no output enable on write", oecnt, 0);
      if (ew > 0) begin
        if (be[0]) shadow[a][7:0]  = wd[7:0];
        if (be[1]) shadow[a][15:8] = wd[15:8];
      end
    end
    exp_turn = nx.tn + 1;
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) begin
      model[i]  = 16'($urandom % 32768);
      shadow[i] = model[i];
    end
    clear_nx();
    apply_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "chip select idle", int'(mem_cs), 1);
    chk("R1", "oe_n idle", int'(mem_oe_n), 1);
    chk("R1", "we_n idle", int'(mem_we_n), 1);
    chk("R1", "lanes idle", int'(mem_bl_n), 3);
    chk("R1", "done idle", int'(rsp_done), 0);
    chk("R1", "ready idle", int'(req_ready), 1);
    cfg_cs_high = 1'b1; #1;
    chk("R2", "active-high select idle level", int'(mem_cs), 0);
    cfg_cs_high = 1'b0; #1;
    chk("R2", "active-low select idle level", int'(mem_cs), 1);

    clear_nx(); nx.rd = 31; nx.oe = 0;
    txn(0, 3, 16'h0, 2'b11, 0);
    clear_nx(); nx.wr = 31; nx.we = 0; nx.csh = 1;
    txn(1, 5, 16'h1234, 2'b11, 0);
    clear_nx(); nx.rd = 4; nx.csh = 1;
    txn(0, 5, 16'h0, 2'b11, 0);
    clear_nx(); nx.wr = 3; nx.we = 1; nx.wp = 1;
    txn(1, 5, 16'h7777, 2'b11, 0);
    clear_nx(); nx.rd = 2;
    txn(0, 5, 16'h0, 2'b11, 0);
    clear_nx(); nx.rd = 3; nx.oe = 15;
    txn(0, 6, 16'h0, 2'b11, 0);
    clear_nx(); nx.wr = 0; nx.we = 0;
    txn(1, 7, 16'h5555, 2'b01, 0);
    clear_nx(); nx.wr = 2; nx.we = 1;
    txn(1, 7, 16'h2AAA, 2'b10, 0);
    clear_nx(); nx.rd = 1;
    txn(0, 7, 16'h0, 2'b10, 0);
    clear_nx(); nx.rd = 9; nx.pg = 0; nx.pgen = 1;
    txn(0, 4, 16'h0, 2'b11, 0);
    txn(0, 5, 16'h0, 2'b11, 0);
    txn(0, 9, 16'h0, 2'b11, 0);
    clear_nx(); nx.rd = 2; nx.ew = 1; nx.tmo = 0;
    txn(0, 1, 16'h0, 2'b11, 60);
    txn(0, 1, 16'h0, 2'b11, 5);
    clear_nx(); nx.rd = 0; nx.tn = 15;
    txn(0, 2, 16'h0, 2'b11, 0);
    clear_nx();
    txn(0, 2, 16'h0, 2'b11, 0);

    for (int n = 0; n < 320; n++) begin
      nx.oe = $urandom % 16;  nx.we = $urandom % 16;
      nx.rd = $urandom % 32;  nx.wr = $urandom % 32;
      nx.pg = $urandom % 32;  nx.tn = $urandom % 16;
      nx.tmo = $urandom % 2;  nx.ew = 1'($urandom % 2);
      nx.pgen = 1'($urandom % 2); nx.csh = 1'($urandom % 2);
      nx.wp = ($urandom % 4) == 0;
      txn(1'($urandom % 2), $urandom % 16, 16'($urandom % 32768),
          2'(($urandom % 3) + 1), $urandom % 51);
    end

    chk("R1", "strobes outside chip select", int'(idle_bad), 0);
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog R8 actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule